// File: doc/BRIEF.md
# I2C Master Register Front-End

This block is the software-facing half of an I2C master. A CPU reaches six byte-wide registers through a simple select/write-enable port with a stall signal. The registers are control, status, data, own slave address, clock divider and input filter rate. The block turns data-register traffic into byte commands for a separate bit engine, which drives SCL and SDA. Four commands exist: open a transfer with an address byte, send a byte, receive a byte, and stop. Each command comes back with an acknowledge result.

Data-register accesses start bus phases. In master mode, the first data write after the cycle state is idle sends the address byte. Later data writes send payload bytes. In master receive mode, a data read returns the held byte and fetches the next one. The front-end also does the following:
- It keeps the completion, pending and NACK flags.
- It drives the interrupt.
- It cleans up an open transfer when the CPU drops master mode or asks for a repeated start.
- It performs a soft reset when the enable bit is cleared. The soft reset leaves the own-address register unchanged.

A CPU access is taken on a rising edge where `cpu_sel` and `cpu_ready` are both high. Read data is valid during that cycle. `cpu_ready` stays low from the cycle a command is issued until the engine reports that it is done.

Top module: `i2cm_regfront`

## Requirements
- R1: After reset, the status register reads 0x81 and every other register reads 0x00. `irq` is low and `cpu_ready` is high.
- R2: The register offsets are 0x00 own address, 0x04 divider, 0x08 control, 0x0C status, 0x10 data and 0x14 filter rate. The filter register keeps all 8 bits. A read of any other offset returns 0x00, and a write to any other offset changes nothing.
- R3: Writes are masked. The own-address register keeps 0xFE, the divider keeps 0x3F, the control register keeps 0xFC and the status register keeps 0xED.
- R4: The control bits are: 7 enable, 6 interrupt enable, 5 master, 4 transmit, 3 transmit-ack and 2 repeated start. The status bits are: 7 transfer complete, 6 addressed, 5 bus busy, 4 arbitration lost, 2 slave read/write, 1 pending and 0 received NACK. A normal control write copies control bit 5 into status bit 5.
- R5: A control write with bit 7 clear, made while the block is enabled, is not stored. Instead it sets the divider, control, data and filter registers to 0, sets status to 0x81 and makes the cycle state idle. The own-address register keeps its value.
- R6: A data write while the block is disabled leaves the data register unchanged and issues no command.
- R7: The engine opcodes are 0 start+address, 1 send, 2 receive and 3 stop. When enabled in master mode, a data write issues opcode 0 with the written byte if the cycle state is idle. Otherwise it issues opcode 1 with the written byte.
- R8: An acknowledged address or data byte clears status bit 0 and sets status bits 7 and 1. An acknowledged address makes a transfer active. A NACKed address sets status bit 0 and leaves the cycle state idle, so the next data write issues opcode 0 again.
- R9: A NACKed data byte sets status bit 0, issues a stop (opcode 3) straight after, and makes the cycle state idle.
- R10: In master receive mode (control bit 5 set, bit 4 clear), a data read returns the current data value and issues opcode 2. A successful receive loads the received byte and sets status bits 7 and 1. A failed receive loads 0xFF.
- R11: A control write with bit 5 clear, made while a transfer is active, issues a stop and makes the cycle state idle. A control write with bits 5 and 2 set, made while a transfer is active, issues a stop, makes the cycle state idle, and stores bit 2 as 0.
- R12: `irq` is high only when control bits 7 and 6 and status bit 1 are all set. A status write that clears bit 1 drops `irq` from the next cycle.
- R13: The command strobe lasts one cycle. `cpu_ready` is low from the strobe until the engine's done pulse, and no CPU access is taken in that window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_sel | input | 1 | CPU access request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Byte offset of the register |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, valid in the access cycle |
| cpu_ready | output | 1 | High when an access can be taken |
| eng_cmd_vld | output | 1 | One-cycle command strobe to the bit engine |
| eng_cmd_op | output | 2 | Command opcode |
| eng_cmd_byte | output | 8 | Command byte operand |
| eng_done | input | 1 | Engine completion pulse |
| eng_ack | input | 1 | Acknowledge result, valid with eng_done |
| eng_rx_byte | input | 8 | Received byte, valid with eng_done |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can fall in the same cycle: the engine's completion of a NACKed payload byte, and the issue of the cleanup stop that follows from it. The bench provokes this by configuring the engine model to refuse a data byte. It then checks three things: the next strobe carries opcode 3, exactly two commands were logged for that one write, and status bit 0 is set. The stall is judged at the edge next to the same boundary. The bench checks that `cpu_ready` is already low in the cycle the strobe is visible, and that the strobe is gone one cycle later.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned OFFS_STRIDE = 4;

    localparam logic [BYTE_W-1:0] OWN_MASK = 8'hFE;
    localparam logic [BYTE_W-1:0] DIV_MASK = 8'h3F;
    localparam logic [BYTE_W-1:0] CTL_MASK = 8'hFC;
    localparam logic [BYTE_W-1:0] STS_MASK = 8'hED;
    localparam logic [BYTE_W-1:0] STS_INIT = 8'h81;
    localparam logic [BYTE_W-1:0] RX_FAIL  = 8'hFF;

    typedef enum logic [2:0] {
        SEL_OWN, SEL_DIV, SEL_CTL, SEL_STS, SEL_DAT, SEL_FLT, SEL_NONE
    } reg_sel_e;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_SEND  = 2'd1,
        OP_RECV  = 2'd2,
        OP_STOP  = 2'd3
    } eng_op_e;

    typedef struct packed {
        logic en;
        logic ien;
        logic master;
        logic tx;
        logic txak;
        logic rsta;
        logic rsvd1;
        logic rsvd0;
    } ctl_t;

    typedef struct packed {
        logic xfer_done;
        logic slave_hit;
        logic bus_busy;
        logic arb_lost;
        logic rsvd3;
        logic slave_rw;
        logic pend;
        logic rx_nack;
    } sts_t;

    typedef struct packed {
        logic     wr;
        logic     rd;
        reg_sel_e sel;
    } cpu_acc_t;

    typedef struct packed {
        logic              vld;
        eng_op_e           op;
        logic [BYTE_W-1:0] data;
    } eng_req_t;

    function automatic reg_sel_e sel_of(input int unsigned off);
        reg_sel_e s;
        s = SEL_NONE;
        for (int i = 0; i < 6; i++) begin
            if (off == i * OFFS_STRIDE) s = reg_sel_e'(i);
        end
        return s;
    endfunction

endpackage

// File: rtl/i2cm_decode.sv
module i2cm_decode
    import i2cm_pkg::*;
#(
    parameter int unsigned ADDR_W = 5
) (
    input  logic              sel,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ready,
    output cpu_acc_t          acc,
    output reg_sel_e          rsel
);
    logic take;

    always_comb begin
        rsel   = sel_of(int'(addr));
        take   = sel && ready;
        acc.wr = take && we;
        acc.rd = take && !we;
        acc.sel = rsel;
    end

endmodule

// File: rtl/i2cm_seq.sv
module i2cm_seq
    import i2cm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  eng_req_t          req,
    input  logic              done,
    output logic              cmd_vld,
    output eng_op_e           cmd_op,
    output logic [BYTE_W-1:0] cmd_byte,
    output logic              ready,
    output logic              rsp_vld
);
    logic busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_vld  <= 1'b0;
            cmd_op   <= OP_START;
            cmd_byte <= '0;
            busy_q   <= 1'b0;
        end else begin
            cmd_vld <= req.vld;
            if (req.vld) begin
                cmd_op   <= req.op;
                cmd_byte <= req.data;
                busy_q   <= 1'b1;
            end else if (done) begin
                busy_q <= 1'b0;
            end
        end
    end

    assign ready   = !busy_q;
    assign rsp_vld = done && busy_q;

endmodule

// File: rtl/i2cm_regbank.sv
module i2cm_regbank
    import i2cm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cpu_acc_t          acc,
    input  reg_sel_e          rsel,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              rsp_vld,
    input  eng_op_e           rsp_op,
    input  logic              rsp_ack,
    input  logic [BYTE_W-1:0] rsp_byte,
    output logic [BYTE_W-1:0] rdata,
    output eng_req_t          req,
    output logic              irq,
    output ctl_t              ctl_q,
    output sts_t              sts_q,
    output logic [BYTE_W-1:0] own_q,
    output logic [BYTE_W-1:0] dat_q
);
    logic [BYTE_W-1:0] div_q;
    logic [BYTE_W-1:0] flt_q;
    logic              cyc_act_q;

    logic wr_ctl, soft_rst, ctl_norm, stop_on_ctl;
    logic wr_dat_go, rd_rx_go, nack_send;

    always_comb begin
        wr_ctl      = acc.wr && (acc.sel == SEL_CTL);
        soft_rst    = wr_ctl && ctl_q.en && !wdata[7];
        ctl_norm    = wr_ctl && !soft_rst;
        stop_on_ctl = ctl_norm && cyc_act_q && (!wdata[5] || wdata[2]);
        wr_dat_go   = acc.wr && (acc.sel == SEL_DAT) && ctl_q.en && ctl_q.master;
        rd_rx_go    = acc.rd && (acc.sel == SEL_DAT) && ctl_q.master && !ctl_q.tx;
        nack_send   = rsp_vld && (rsp_op == OP_SEND) && !rsp_ack;
    end

    always_comb begin
        req.vld  = 1'b0;
        req.op   = OP_STOP;
        req.data = '0;
        if (nack_send || stop_on_ctl) begin
            req.vld = 1'b1;
        end else if (wr_dat_go) begin
            req.vld  = 1'b1;
            req.op   = cyc_act_q ? OP_SEND : OP_START;
            req.data = wdata;
        end else if (rd_rx_go) begin
            req.vld = 1'b1;
            req.op  = OP_RECV;
        end
    end

    always_comb begin
        unique case (rsel)
            SEL_OWN: rdata = own_q;
            SEL_DIV: rdata = div_q;
            SEL_CTL: rdata = ctl_q;
            SEL_STS: rdata = sts_q;
            SEL_DAT: rdata = dat_q;
            SEL_FLT: rdata = flt_q;
            default: rdata = '0;
        endcase
    end

    assign irq = ctl_q.en && ctl_q.ien && sts_q.pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            own_q     <= '0;
            div_q     <= '0;
            ctl_q     <= '0;
            sts_q     <= STS_INIT;
            dat_q     <= '0;
            flt_q     <= '0;
            cyc_act_q <= 1'b0;
        end else begin
            if (soft_rst) begin
                div_q     <= '0;
                ctl_q     <= '0;
                sts_q     <= STS_INIT;
                dat_q     <= '0;
                flt_q     <= '0;
                cyc_act_q <= 1'b0;
            end else if (ctl_norm) begin
                ctl_q          <= ctl_t'(wdata & CTL_MASK);
                sts_q.bus_busy <= wdata[5];
                if (stop_on_ctl) begin
                    cyc_act_q <= 1'b0;
                    if (wdata[5]) ctl_q.rsta <= 1'b0;
                end
            end

            if (acc.wr) begin
                unique case (acc.sel)
                    SEL_OWN: own_q <= wdata & OWN_MASK;
                    SEL_DIV: div_q <= wdata & DIV_MASK;
                    SEL_STS: sts_q <= sts_t'(wdata & STS_MASK);
                    SEL_DAT: if (ctl_q.en) dat_q <= wdata;
                    SEL_FLT: flt_q <= wdata;
                    default: ;
                endcase
            end

            if (rsp_vld) begin
                unique case (rsp_op)
                    OP_START, OP_SEND: begin
                        if (rsp_ack) begin
                            sts_q.rx_nack   <= 1'b0;
                            sts_q.xfer_done <= 1'b1;
                            sts_q.pend      <= 1'b1;
                            if (rsp_op == OP_START) cyc_act_q <= 1'b1;
                        end else begin
                            sts_q.rx_nack <= 1'b1;
                            if (rsp_op == OP_SEND) cyc_act_q <= 1'b0;
                        end
                    end
                    OP_RECV: begin
                        if (rsp_ack) begin
                            dat_q           <= rsp_byte;
                            sts_q.xfer_done <= 1'b1;
                            sts_q.pend      <= 1'b1;
                        end else begin
                            dat_q <= RX_FAIL;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/i2cm_regfront.sv
module i2cm_regfront
    import i2cm_pkg::*;
#(
    parameter int unsigned ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_sel,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [7:0]        cpu_wdata,
    output logic [7:0]        cpu_rdata,
    output logic              cpu_ready,
    output logic              eng_cmd_vld,
    output logic [1:0]        eng_cmd_op,
    output logic [7:0]        eng_cmd_byte,
    input  logic              eng_done,
    input  logic              eng_ack,
    input  logic [7:0]        eng_rx_byte,
    output logic              irq
);
    cpu_acc_t          acc;
    reg_sel_e          rsel;
    eng_req_t          req;
    eng_op_e           cur_op;
    logic              rsp_vld;
    ctl_t              ctl_vec;
    sts_t              sts_vec;
    logic [BYTE_W-1:0] own_vec;
    logic [BYTE_W-1:0] dat_vec;

    i2cm_decode #(.ADDR_W(ADDR_W)) u_dec (
        .sel   (cpu_sel),
        .we    (cpu_we),
        .addr  (cpu_addr),
        .ready (cpu_ready),
        .acc   (acc),
        .rsel  (rsel)
    );

    i2cm_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .done     (eng_done),
        .cmd_vld  (eng_cmd_vld),
        .cmd_op   (cur_op),
        .cmd_byte (eng_cmd_byte),
        .ready    (cpu_ready),
        .rsp_vld  (rsp_vld)
    );

    assign eng_cmd_op = cur_op;

    i2cm_regbank u_regs (
        .clk      (clk),
        .rst      (rst),
        .acc      (acc),
        .rsel     (rsel),
        .wdata    (cpu_wdata),
        .rsp_vld  (rsp_vld),
        .rsp_op   (cur_op),
        .rsp_ack  (eng_ack),
        .rsp_byte (eng_rx_byte),
        .rdata    (cpu_rdata),
        .req      (req),
        .irq      (irq),
        .ctl_q    (ctl_vec),
        .sts_q    (sts_vec),
        .own_q    (own_vec),
        .dat_q    (dat_vec)
    );

endmodule

// File: rtl/i2cm_regfront_chk.sv
module i2cm_regfront_chk #(
    parameter int unsigned ADDR_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_sel,
    input logic              cpu_we,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic [7:0]        cpu_wdata,
    input logic              cpu_ready,
    input logic              eng_cmd_vld,
    input logic [1:0]        eng_cmd_op,
    input logic              eng_done,
    input logic              eng_ack,
    input logic              irq,
    input logic [7:0]        ctl_vec,
    input logic [7:0]        sts_vec,
    input logic [7:0]        own_vec,
    input logic [7:0]        dat_vec
);
    logic take_wr;
    assign take_wr = cpu_sel && cpu_ready && cpu_we;

    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (sts_vec == 8'h81) && cpu_ready && !irq);

    a_r13_strobe_single: assert property (@(posedge clk) disable iff (rst)
        eng_cmd_vld |=> !eng_cmd_vld);

    a_r13_stall_with_cmd: assert property (@(posedge clk) disable iff (rst)
        eng_cmd_vld |-> !cpu_ready);

    a_r6_dat_hold_disabled: assert property (@(posedge clk) disable iff (rst)
        (take_wr && cpu_addr == ADDR_W'(8'h10) && !ctl_vec[7]) |=> $stable(dat_vec));

    a_r5_own_kept: assert property (@(posedge clk) disable iff (rst)
        (take_wr && cpu_addr == ADDR_W'(8'h08) && ctl_vec[7] && !cpu_wdata[7])
        |=> $stable(own_vec) && (sts_vec == 8'h81) && (ctl_vec == 8'h00));

    a_r4_busy_follows_master: assert property (@(posedge clk) disable iff (rst)
        (take_wr && cpu_addr == ADDR_W'(8'h08) && (ctl_vec[7] || !cpu_wdata[7]) == 1'b0 ? 1'b0 :
         (take_wr && cpu_addr == ADDR_W'(8'h08) && !(ctl_vec[7] && !cpu_wdata[7])))
        |=> sts_vec[5] == $past(cpu_wdata[5]));

    a_r9_stop_after_nack: assert property (@(posedge clk) disable iff (rst)
        (eng_done && !cpu_ready && eng_cmd_op == 2'd1 && !eng_ack)
        |=> eng_cmd_vld && eng_cmd_op == 2'd3);

    a_r12_irq_drop_on_clear: assert property (@(posedge clk) disable iff (rst)
        (take_wr && cpu_addr == ADDR_W'(8'h0C) && !cpu_wdata[1]) |=> !irq);

endmodule

bind i2cm_regfront i2cm_regfront_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cpu_sel     (cpu_sel),
    .cpu_we      (cpu_we),
    .cpu_addr    (cpu_addr),
    .cpu_wdata   (cpu_wdata),
    .cpu_ready   (cpu_ready),
    .eng_cmd_vld (eng_cmd_vld),
    .eng_cmd_op  (eng_cmd_op),
    .eng_done    (eng_done),
    .eng_ack     (eng_ack),
    .irq         (irq),
    .ctl_vec     (ctl_vec),
    .sts_vec     (sts_vec),
    .own_vec     (own_vec),
    .dat_vec     (dat_vec)
);

// File: tb/sim_i2cm_regfront.sv
module sim_i2cm_regfront;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 5;
    localparam int NVEC = 7;

    localparam logic [4:0] V_ADDR [NVEC] = '{5'h00, 5'h04, 5'h14, 5'h08, 5'h0C, 5'h18, 5'h02};
    localparam logic [7:0] V_WD   [NVEC] = '{8'hFF, 8'hFF, 8'hA5, 8'h0F, 8'hFF, 8'h55, 8'h55};
    localparam logic [7:0] V_EXP  [NVEC] = '{8'hFE, 8'h3F, 8'hA5, 8'h0C, 8'hED, 8'h00, 8'h00};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cpu_sel = 1'b0, cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic cpu_ready, eng_cmd_vld, irq;
    logic [1:0] eng_cmd_op;
    logic [7:0] eng_cmd_byte;
    logic eng_done = 1'b0, eng_ack = 1'b0;
    logic [7:0] eng_rx_byte = '0;

    logic ack_cfg = 1'b1;
    logic [7:0] rx_cfg = '0;
    int lat = 0;
    int ncmd = 0;
    logic [1:0] log_op = '0;
    logic [7:0] log_byte = '0;
    int nchk = 0, nerr = 0, cyc = 0;

    i2cm_regfront #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .cpu_sel(cpu_sel), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_ready(cpu_ready), .eng_cmd_vld(eng_cmd_vld), .eng_cmd_op(eng_cmd_op),
        .eng_cmd_byte(eng_cmd_byte), .eng_done(eng_done), .eng_ack(eng_ack),
        .eng_rx_byte(eng_rx_byte), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // bit engine model: done three cycles after the strobe
    always @(posedge clk) begin
        eng_done <= 1'b0;
        if (rst) begin
            lat <= 0;
        end else if (eng_cmd_vld) begin
            lat      <= 3;
            log_op   <= eng_cmd_op;
            log_byte <= eng_cmd_byte;
            ncmd     <= ncmd + 1;
        end else if (lat > 0) begin
            lat <= lat - 1;
            if (lat == 1) begin
                eng_done    <= 1'b1;
                eng_ack     <= (log_op == 2'd3) ? 1'b1 : ack_cfg;
                eng_rx_byte <= rx_cfg;
            end
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            nerr = nerr + 1;
            $display("FAIL watchdog act=%0d exp=<100000", cyc);
            $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        nchk = nchk + 1;
        if (act !== exp) begin
            nerr = nerr + 1;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic cpu_wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        while (!cpu_ready) @(negedge clk);
        cpu_sel = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_sel = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic cpu_rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        while (!cpu_ready) @(negedge clk);
        cpu_sel = 1'b1; cpu_we = 1'b0; cpu_addr = a;
        #1 d = cpu_rdata;
        @(negedge clk);
        cpu_sel = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk);
        while (!cpu_ready) @(negedge clk);
        @(negedge clk);
    endtask

    logic [7:0] rv;
    int n0;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check("R1 ready", {7'd0, cpu_ready}, 8'h01);
        check("R1 irq", {7'd0, irq}, 8'h00);
        cpu_rd(5'h0C, rv); check("R1 status", rv, 8'h81);
        for (int i = 0; i < 6; i++) begin
            if (i != 3) begin
                cpu_rd(5'(i * 4), rv);
                check("R1 reg zero", rv, 8'h00);
            end
        end

        // R2 / R3: mask and offset table
        for (int i = 0; i < NVEC; i++) begin
            cpu_wr(V_ADDR[i], V_WD[i]);
            cpu_rd(V_ADDR[i], rv);
            check("R2/R3 table", rv, V_EXP[i]);
        end

        // R5: soft reset keeps own address
        cpu_wr(5'h08, 8'hC0);
        cpu_wr(5'h04, 8'h12);
        cpu_wr(5'h08, 8'h00);
        cpu_rd(5'h00, rv); check("R5 own kept", rv, 8'hFE);
        cpu_rd(5'h04, rv); check("R5 div cleared", rv, 8'h00);
        cpu_rd(5'h14, rv); check("R5 filter cleared", rv, 8'h00);
        cpu_rd(5'h0C, rv); check("R5 status", rv, 8'h81);
        cpu_rd(5'h08, rv); check("R5 control", rv, 8'h00);

        // R6: data write ignored while disabled
        n0 = ncmd;
        cpu_wr(5'h10, 8'h77);
        settle();
        cpu_rd(5'h10, rv); check("R6 data held", rv, 8'h00);
        check("R6 no command", 8'(ncmd - n0), 8'h00);

        // R4: master bit raises bus busy
        cpu_wr(5'h08, 8'hF0);
        cpu_rd(5'h0C, rv); check("R4 busy set", rv, 8'hA1);
        cpu_wr(5'h0C, 8'h00);

        // R7/R8/R13: address phase
        ack_cfg = 1'b1;
        cpu_wr(5'h10, 8'hA0);
        check("R13 strobe", {7'd0, eng_cmd_vld}, 8'h01);
        check("R13 stall", {7'd0, cpu_ready}, 8'h00);
        @(negedge clk);
        check("R13 strobe one cycle", {7'd0, eng_cmd_vld}, 8'h00);
        check("R13 still stalled", {7'd0, cpu_ready}, 8'h00);
        settle();
        check("R7 start op", {6'd0, log_op}, 8'h00);
        check("R7 start byte", log_byte, 8'hA0);
        cpu_rd(5'h0C, rv); check("R8 ack status", rv, 8'h82);
        check("R12 irq high", {7'd0, irq}, 8'h01);
        cpu_wr(5'h0C, 8'h80);
        check("R12 irq cleared", {7'd0, irq}, 8'h00);

        // R7: payload byte
        cpu_wr(5'h10, 8'h3C);
        settle();
        check("R7 send op", {6'd0, log_op}, 8'h01);
        check("R7 send byte", log_byte, 8'h3C);
        cpu_rd(5'h0C, rv); check("R8 send ack status", rv, 8'h82);

        // R9: NACK on payload issues stop
        ack_cfg = 1'b0;
        n0 = ncmd;
        cpu_wr(5'h10, 8'h99);
        settle();
        check("R9 stop op", {6'd0, log_op}, 8'h03);
        check("R9 two commands", 8'(ncmd - n0), 8'h02);
        cpu_rd(5'h0C, rv); check("R9 nack bit", rv, 8'h83);
        ack_cfg = 1'b1;
        cpu_wr(5'h10, 8'hB1);
        settle();
        check("R9 idle then start", {6'd0, log_op}, 8'h00);

        // R11: master clear ends transfer
        n0 = ncmd;
        cpu_wr(5'h08, 8'hD0);
        settle();
        check("R11 stop on master clear", {6'd0, log_op}, 8'h03);
        check("R11 one stop", 8'(ncmd - n0), 8'h01);
        cpu_rd(5'h0C, rv); check("R11 busy dropped", rv, 8'h82);

        // R8: address NACK leaves cycle idle
        cpu_wr(5'h08, 8'hF0);
        ack_cfg = 1'b0;
        cpu_wr(5'h10, 8'hC2);
        settle();
        cpu_rd(5'h0C, rv); check("R8 addr nack", rv, 8'hA3);
        ack_cfg = 1'b1;
        cpu_wr(5'h10, 8'hC4);
        settle();
        check("R8 start again", {6'd0, log_op}, 8'h00);
        check("R8 start byte", log_byte, 8'hC4);

        // R11: repeated start
        n0 = ncmd;
        cpu_wr(5'h08, 8'hF4);
        settle();
        check("R11 rsta stop", {6'd0, log_op}, 8'h03);
        check("R11 rsta one cmd", 8'(ncmd - n0), 8'h01);
        cpu_rd(5'h08, rv); check("R11 rsta cleared", rv, 8'hF0);
        cpu_wr(5'h10, 8'hD0);
        settle();
        check("R11 restart", {6'd0, log_op}, 8'h00);

        // R10: receive
        cpu_wr(5'h08, 8'hE0);
        cpu_wr(5'h0C, 8'h20);
        rx_cfg = 8'h5A;
        cpu_rd(5'h10, rv); check("R10 current value", rv, 8'hD0);
        settle();
        check("R10 recv op", {6'd0, log_op}, 8'h02);
        cpu_rd(5'h0C, rv); check("R10 recv status", rv, 8'hA2);
        check("R12 irq recv", {7'd0, irq}, 8'h01);
        ack_cfg = 1'b0;
        cpu_rd(5'h10, rv); check("R10 received byte", rv, 8'h5A);
        settle();
        cpu_rd(5'h10, rv); check("R10 failed receive", rv, 8'hFF);
        settle();

        // R12: interrupt enable gates irq
        cpu_wr(5'h08, 8'hA0);
        cpu_rd(5'h0C, rv); check("R12 pending kept", rv, 8'hA2);
        check("R12 irq gated", {7'd0, irq}, 8'h00);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule